// File: doc/BRIEF.md
# Lane-Group Memory Request Splitter

This block sits between the issue stage and the memory pipeline of a parallel processor. One memory instruction arrives for a group of 32 lanes. The instruction carries a mask of active lanes, one address for each lane, a per-lane size code and a mode bit. The block cuts the instruction into a sequence of downstream transactions. Each transaction carries the mask of the lanes it serves and a base address.

The cut depends on the mode. In legacy mode each half-group of 16 lanes is a separate piece. In full mode all 32 lanes form one piece, unless the payload would go over the 128-byte transaction limit. In that case the block falls back to half-group pieces. At 16 bytes per lane even a half-group is too large, so pieces of 8 lanes are used in either mode. Pieces that have no active lane are skipped. The instruction is held in the block until its last transaction has been accepted.

The controller has three states. IDLE accepts an instruction (transition *capture*, IDLE to SCAN). SCAN inspects the current piece and takes one of three transitions: *hit* goes to SEND when the piece has active lanes, *skip* stays in SCAN and moves to the next piece, and *drain* returns to IDLE when the last piece is empty. SEND presents the transaction. It takes *next* (back to SCAN with the following piece) or *finish* (to IDLE after the last piece) once the transaction is accepted, and *hold* (stays in SEND) while downstream is not ready.

Top module: `warp_req_splitter`

## Requirements
- R1: After reset, `in_ready` is 1 and `tx_valid` is 0.
- R2: Size code 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes per lane. Codes 5 to 7 behave like code 4.
- R3: With `in_full` = 0 (legacy mode) and sizes up to 8 bytes, lanes 0-15 form one piece and lanes 16-31 form another.
- R4: With `in_full` = 1 and sizes up to 4 bytes, all active lanes go out in a single transaction.
- R5: With `in_full` = 1 and 8 bytes per lane, the instruction is split into the two half-group pieces.
- R6: At 16 bytes per lane, in either mode, pieces are lanes 0-7, 8-15, 16-23 and 24-31.
- R7: A piece with no active lane emits no transaction. An all-zero mask is accepted and produces no transaction.
- R8: Transactions leave in ascending lane order.
- R9: `tx_mask` holds exactly the active lanes of its piece. `tx_base` is the address of the lowest active lane in that piece.
- R10: `in_ready` is 0 from the acceptance of an instruction until its last transaction is accepted. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_mask` and `tx_base` hold their values.
- R11: No transaction carries more than 128 bytes, counted as active lanes times bytes per lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when both are high |
| in_full | input | 1 | 1 = full-group mode, 0 = legacy half-group mode |
| in_size | input | 3 | Per-lane size code |
| in_mask | input | 32 | Active-lane mask, bit i = lane i |
| in_addr | input | 1024 | Lane addresses, lane i in bits [32i+31:32i] |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Transaction accepted when both are high |
| tx_mask | output | 32 | Lanes served by this transaction |
| tx_base | output | 32 | Address of the lowest lane in `tx_mask` |

## Verification
Several properties are checked on every cycle: the input and output sides are never ready and valid at the same time, an offered transaction is never empty, its byte count stays within the limit, and it stays frozen under backpressure. An empty-mask instruction is also checked to produce nothing on the following cycle. The exact piece boundaries for each mode and size, the skipping of empty pieces, the ascending order and the choice of base lane can only be shown by the bench. The bench compares every emitted transaction against a list it builds from the mask, size and mode.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SEND
    } wrs_state_e;

    localparam int SIZE_CODE_MAX = 4;

    // Codes above the largest defined one saturate (R2)
    function automatic logic [2:0] clamp_size(input logic [2:0] code);
        return (code > 3'(SIZE_CODE_MAX)) ? 3'(SIZE_CODE_MAX) : code;
    endfunction

endpackage

// File: rtl/wrs_piece_plan.sv
module wrs_piece_plan
    import wrs_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int HALF_LANES = 16,
    parameter int MAX_BYTES  = 128,
    parameter int LG_W       = 3,
    parameter int IDX_W      = 5
) (
    input  logic             full_mode,
    input  logic [2:0]       size_code,
    output logic [LG_W-1:0]  lg_lanes,
    output logic [IDX_W-1:0] last_idx,
    output logic [4:0]       lane_bytes
);
    localparam int LG_LANES = $clog2(LANES);
    localparam int LG_HALF  = $clog2(HALF_LANES);
    localparam int LG_MAXB  = $clog2(MAX_BYTES);

    logic [2:0] sz;
    int         lg_i;
    int         fit_i;

    always_comb begin
        sz         = clamp_size(size_code);
        lane_bytes = 5'(1) << sz;
        lg_i       = full_mode ? LG_LANES : LG_HALF;
        fit_i      = LG_MAXB - int'(sz);
        if (fit_i < lg_i) begin
            lg_i = fit_i;
        end
        if (lg_i < 0) begin
            lg_i = 0;
        end
        lg_lanes = LG_W'(lg_i);
        last_idx = IDX_W'((LANES >> lg_i) - 1);
    end

endmodule

// File: rtl/wrs_lane_select.sv
module wrs_lane_select #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int LG_W   = 3,
    parameter int IDX_W  = 5
) (
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [IDX_W-1:0]        piece_idx,
    input  logic [LG_W-1:0]         lg_lanes,
    output logic [LANES-1:0]        piece_mask,
    output logic [ADDR_W-1:0]       piece_base,
    output logic                    piece_any
);
    logic [LANES-1:0] window;

    // Lane g belongs to piece (g >> lg_lanes)
    for (genvar g = 0; g < LANES; g++) begin : g_win
        assign window[g] = ((IDX_W'(g) >> lg_lanes) == piece_idx);
    end

    assign piece_mask = lane_mask & window;
    assign piece_any  = |piece_mask;

    // Lowest active lane wins the base (R9)
    always_comb begin
        piece_base = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (piece_mask[i]) begin
                piece_base = lane_addr[i*ADDR_W +: ADDR_W];
            end
        end
    end

endmodule

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
    import wrs_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             tx_ready,
    input  logic             piece_any,
    input  logic [IDX_W-1:0] last_idx,
    output logic             in_ready,
    output logic             tx_valid,
    output logic             capture,
    output logic [IDX_W-1:0] piece_idx
);
    wrs_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_d;
    logic             is_last;

    assign is_last = (piece_idx == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            piece_idx <= '0;
        end else begin
            state_q   <= state_d;
            piece_idx <= idx_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        idx_d    = piece_idx;
        in_ready = 1'b0;
        tx_valid = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin           // capture
                    capture = 1'b1;
                    idx_d   = '0;
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (piece_any) begin          // hit
                    state_d = ST_SEND;
                end else if (is_last) begin   // drain
                    state_d = ST_IDLE;
                end else begin                // skip
                    idx_d = piece_idx + 1'b1;
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    if (is_last) begin        // finish
                        state_d = ST_IDLE;
                    end else begin            // next
                        idx_d   = piece_idx + 1'b1;
                        state_d = ST_SCAN;
                    end
                end                           // hold otherwise
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_SIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && tx_valid)); // R10

    AST_HOLD_PIECE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(piece_idx))); // R10

endmodule

// File: rtl/warp_req_splitter.sv
module warp_req_splitter
    import wrs_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int HALF_LANES = 16,
    parameter int ADDR_W     = 32,
    parameter int MAX_BYTES  = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_full,
    input  logic [2:0]              in_size,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [LANES-1:0]        tx_mask,
    output logic [ADDR_W-1:0]       tx_base
);
    localparam int LG_LANES = $clog2(LANES);
    localparam int LG_W     = $clog2(LG_LANES + 1);
    localparam int IDX_W    = LG_LANES;

    logic                    cap_full;
    logic [2:0]              cap_size;
    logic [LANES-1:0]        cap_mask;
    logic [LANES*ADDR_W-1:0] cap_addr;

    logic                    capture;
    logic [IDX_W-1:0]        piece_idx;
    logic [IDX_W-1:0]        last_idx;
    logic [LG_W-1:0]         lg_lanes;
    logic [4:0]              lane_bytes;
    logic                    piece_any;
    logic [LANES-1:0]        piece_mask;
    logic [ADDR_W-1:0]       piece_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_full <= 1'b0;
            cap_size <= '0;
            cap_mask <= '0;
            cap_addr <= '0;
        end else if (capture) begin
            cap_full <= in_full;
            cap_size <= in_size;
            cap_mask <= in_mask;
            cap_addr <= in_addr;
        end
    end

    wrs_piece_plan #(
        .LANES(LANES), .HALF_LANES(HALF_LANES), .MAX_BYTES(MAX_BYTES),
        .LG_W(LG_W), .IDX_W(IDX_W)
    ) u_plan (
        .full_mode (cap_full),
        .size_code (cap_size),
        .lg_lanes  (lg_lanes),
        .last_idx  (last_idx),
        .lane_bytes(lane_bytes)
    );

    wrs_lane_select #(
        .LANES(LANES), .ADDR_W(ADDR_W), .LG_W(LG_W), .IDX_W(IDX_W)
    ) u_sel (
        .lane_mask (cap_mask),
        .lane_addr (cap_addr),
        .piece_idx (piece_idx),
        .lg_lanes  (lg_lanes),
        .piece_mask(piece_mask),
        .piece_base(piece_base),
        .piece_any (piece_any)
    );

    wrs_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .tx_ready (tx_ready),
        .piece_any(piece_any),
        .last_idx (last_idx),
        .in_ready (in_ready),
        .tx_valid (tx_valid),
        .capture  (capture),
        .piece_idx(piece_idx)
    );

    assign tx_mask = tx_valid ? piece_mask : '0;
    assign tx_base = tx_valid ? piece_base : '0;

    AST_TX_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_mask != '0)); // R7

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_mask == '0)) |=> !tx_valid); // R7

    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($countones(tx_mask) * int'(lane_bytes) <= MAX_BYTES)); // R11

    AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> ($stable(tx_mask) && $stable(tx_base))); // R10

endmodule

// File: tb/sim_warp_req_splitter.sv
`timescale 1ns/1ps
module sim_warp_req_splitter;
    localparam int LANES  = 32;
    localparam int ADDR_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic                    in_full = 1'b0;
    logic [2:0]              in_size = '0;
    logic [LANES-1:0]        in_mask = '0;
    logic [LANES*ADDR_W-1:0] in_addr = '0;
    logic                    tx_valid;
    logic                    tx_ready = 1'b0;
    logic [LANES-1:0]        tx_mask;
    logic [ADDR_W-1:0]       tx_base;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] lane_addr [LANES];
    logic [31:0] exp_mask [LANES];
    logic [31:0] exp_base [LANES];
    int          exp_n;
    logic [31:0] got_mask [LANES];
    logic [31:0] got_base [LANES];
    int          got_n;

    always #2.5 clk = ~clk;

    warp_req_splitter u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_full(in_full), .in_size(in_size),
        .in_mask(in_mask), .in_addr(in_addr),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_mask(tx_mask), .tx_base(tx_base)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Independent model of the split rules (R2..R9)
    task automatic build_expect(input logic [31:0] mask, input int size, input bit full);
        int bytes;
        int lanes;
        bytes = 1 << ((size > 4) ? 4 : size);
        lanes = full ? 32 : 16;
        while (lanes * bytes > 128) lanes = lanes / 2;
        exp_n = 0;
        for (int p = 0; p < 32 / lanes; p++) begin
            logic [31:0] m;
            logic [31:0] b;
            bit found;
            m = '0; b = '0; found = 0;
            for (int l = p * lanes; l < (p + 1) * lanes; l++) begin
                if (mask[l]) begin
                    m[l] = 1'b1;
                    if (!found) begin b = lane_addr[l]; found = 1; end
                end
            end
            if (found) begin
                exp_mask[exp_n] = m;
                exp_base[exp_n] = b;
                exp_n++;
            end
        end
    endtask

    task automatic run(input string req, input logic [31:0] mask, input int size,
                       input bit full, input bit stall, input logic [31:0] seed);
        int cyc;
        int bytes;
        bit was_stalled;
        logic [31:0] prev_m;
        logic [31:0] prev_b;
        bytes = 1 << ((size > 4) ? 4 : size);
        for (int i = 0; i < LANES; i++) begin
            lane_addr[i] = seed + 32'(i * 48) + 32'((i % 5) * 4);
            in_addr[i*ADDR_W +: ADDR_W] = lane_addr[i];
        end
        build_expect(mask, size, full);
        @(negedge clk);
        check(req, "in_ready before issue (R10)", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        in_mask  = mask;
        in_size  = 3'(size);
        in_full  = full;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "in_ready after capture (R10)", 32'(in_ready), 32'd0);
        got_n = 0; cyc = 0; was_stalled = 0; prev_m = '0; prev_b = '0;
        while (!in_ready) begin
            tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
            cyc++;
            #0.5;
            if (was_stalled) begin
                check(req, "held mask (R10)", tx_mask, prev_m);
                check(req, "held base (R10)", tx_base, prev_b);
            end
            was_stalled = 0;
            if (tx_valid) begin
                check(req, "byte limit (R11)",
                      32'($countones(tx_mask) * bytes <= 128), 32'd1);
                if (tx_ready) begin
                    if (got_n < LANES) begin
                        got_mask[got_n] = tx_mask;
                        got_base[got_n] = tx_base;
                    end
                    got_n++;
                end else begin
                    was_stalled = 1;
                    prev_m = tx_mask;
                    prev_b = tx_base;
                end
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check(req, "transaction count", 32'(got_n), 32'(exp_n));
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            check(req, $sformatf("mask #%0d in order (R8, R9)", k), got_mask[k], exp_mask[k]);
            check(req, $sformatf("base #%0d lowest lane (R9)", k), got_base[k], exp_base[k]);
        end
    endtask

    task automatic t_reset();
        #0.5;
        check("R1", "in_ready at reset", 32'(in_ready), 32'd1);
        check("R1", "tx_valid at reset", 32'(tx_valid), 32'd0);
    endtask

    task automatic t_legacy();
        run("R3", 32'hFFFF_FFFF, 2, 1'b0, 1'b0, 32'h1000_0000);
        run("R3", 32'hF0F0_0F0F, 3, 1'b0, 1'b0, 32'h2000_0100);
    endtask

    task automatic t_full_small();
        run("R4", 32'hFFFF_FFFF, 2, 1'b1, 1'b0, 32'h3000_0000);
        run("R4", 32'h8000_0100, 0, 1'b1, 1'b0, 32'h3100_0040);
        run("R2", 32'h0F0F_F0F0, 1, 1'b1, 1'b0, 32'h3200_0000);
    endtask

    task automatic t_full_wide();
        run("R5", 32'hFFFF_FFFF, 3, 1'b1, 1'b0, 32'h4000_0000);
        run("R6", 32'hFFFF_FFFF, 4, 1'b1, 1'b0, 32'h5000_0000);
        run("R6", 32'h00FF_FF00, 4, 1'b0, 1'b0, 32'h5100_0000);
        run("R2", 32'hFFFF_FFFF, 6, 1'b1, 1'b0, 32'h5200_0000);
    endtask

    task automatic t_empty();
        run("R7", 32'hFFFF_0000, 2, 1'b0, 1'b0, 32'h6000_0000);
        run("R7", 32'h0000_0000, 2, 1'b1, 1'b0, 32'h6100_0000);
        run("R7", 32'h0F00_000F, 4, 1'b1, 1'b0, 32'h6200_0000);
    endtask

    task automatic t_backpressure();
        run("R10", 32'hA5A5_5A5A, 4, 1'b1, 1'b1, 32'h7000_0000);
        run("R10", 32'h0001_8000, 3, 1'b0, 1'b1, 32'h7100_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_legacy();
        t_full_small();
        t_full_wide();
        t_empty();
        t_backpressure();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule